// File: doc/BRIEF.md
# Single-Wire Bus Transmit Gate

This block sits between a host's transmit-data line and the control inputs of a single-wire bus transmitter. It decides, cycle by cycle, whether the driver may pull the bus dominant. When it does, it also picks the drive level (normal or high-voltage) and says whether edge wave shaping should be active. It combines the host data with the operating mode, a supply-band flag and a stuck-input watchdog.

The host data input is asynchronous, so it first passes through a two-flop synchronizer. A low level on the synchronized data asks for a dominant bit. A timeout counter advances on an external timebase tick while the data stays low. Once that counter reaches its limit, the driver is released. It stays released until the data goes high again, and the next low bit is then driven with the normal latency. The analog driver, the slew shaping and the supply comparators lie outside this block and appear only as flags.

Top module: `swbus_tx_gate`

## Requirements
- R1: A low level on `txd_in` asserts `drv_en` two clock edges after it is applied. A high level on `txd_in` deasserts `drv_en` with the same two-edge latency. This holds when the mode is active and the supply is not locked out.
- R2: When `mode_sel` is 2'b00 (sleep), `drv_en` is 0 whatever the level of `txd_in`.
- R3: `drv_hv` is 1 only while `drv_en` is 1, `mode_sel` is 2'b10 (high-voltage wake-up) and `supply_band[1]` is 1 (full supply). In modes 2'b01 (high-speed) and 2'b11 (normal), a dominant bit has `drv_hv` at 0.
- R4: `shape_en` is 0 when `mode_sel` is 2'b01 (high-speed) and 1 for every other mode.
- R5: If the synchronized data stays low for `TIMEOUT_TICKS` ticks, `drv_en` drops to 0 in the clock cycle that samples the last of those ticks.
- R6: After a timeout, `drv_en` stays 0 while the data stays low. Once the data has gone high, the next low level is driven again after the same two-edge latency as in R1.
- R7: When `supply_band` is 2'b00 (lockout), `drv_en` and `drv_hv` are 0.
- R8: When `supply_band` is 2'b01 (reduced supply), a dominant bit in high-voltage wake-up mode has `drv_en` at 1 and `drv_hv` at 0.
- R9: The timeout count clears whenever the synchronized data is high, and ticks that arrive while it is high are not counted.
- R10: After reset the synchronizer holds the recessive value, so `drv_en` and `drv_hv` are 0 until a low data level has passed through it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_in | input | 1 | Host transmit data, asynchronous; 0 requests dominant |
| mode_sel | input | 2 | Operating mode: 00 sleep, 01 high-speed, 10 high-voltage wake-up, 11 normal |
| supply_band | input | 2 | Supply state: 00 lockout, 01 reduced, 1x full |
| tick | input | 1 | One-cycle timebase pulse for the timeout |
| drv_en | output | 1 | Driver enable (bus dominant) |
| drv_hv | output | 1 | Select the high-voltage dominant level |
| shape_en | output | 1 | Enable edge wave shaping |

## Verification
The assertions assume that `tick` is a single-cycle pulse. They also assume that `mode_sel` and `supply_band` come from logic already synchronous to `clk`, because both feed the outputs with no register in between. The bench drives every input on the falling clock edge, so each input is stable at the rising edge. It raises `tick` for one cycle at a time, and it changes mode and supply only while the driver state is otherwise settled. Timeout scenarios hold the data low across counted ticks and compare against a tick count worked out from the parameter.

// File: rtl/swbus_tx_gate.sv
module swbus_tx_gate #(
  parameter int TIMEOUT_TICKS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txd_in,
  input  logic [1:0] mode_sel,
  input  logic [1:0] supply_band,
  input  logic       tick,
  output logic       drv_en,
  output logic       drv_hv,
  output logic       shape_en
);
  localparam int CW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);
  localparam logic [1:0] M_SLEEP = 2'b00;
  localparam logic [1:0] M_FAST  = 2'b01;
  localparam logic [1:0] M_WAKE  = 2'b10;
  localparam logic [1:0] S_LOCK  = 2'b00;

  logic          sync_a, txd_s;
  logic          stuck;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b1;
      txd_s  <= 1'b1;
    end else begin
      sync_a <= txd_in;
      txd_s  <= sync_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      stuck <= 1'b0;
    end else if (txd_s) begin
      cnt   <= '0;
      stuck <= 1'b0;
    end else if (tick && !stuck) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) stuck <= 1'b1;
    end
  end

  wire active = (mode_sel != M_SLEEP) && (supply_band != S_LOCK);

  assign drv_en   = !txd_s && !stuck && active;
  assign drv_hv   = drv_en && (mode_sel == M_WAKE) && supply_band[1];
  assign shape_en = (mode_sel != M_FAST);

  a_r2_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == M_SLEEP) |-> !drv_en);
  a_r7_lockout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_band == S_LOCK) |-> (!drv_en && !drv_hv));
  a_r3_hv_only_wake: assert property (@(posedge clk) disable iff (!rst_n)
    drv_hv |-> (drv_en && mode_sel == M_WAKE));
  a_r8_no_hv_reduced: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_band == 2'b01) |-> !drv_hv);
  a_r5_timeout_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stuck) |-> (!drv_en && $past(tick)));
  a_r6_release_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stuck) |-> $past(txd_s));
  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(TIMEOUT_TICKS));
  a_r9_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    txd_s |=> (cnt == '0));
endmodule

// File: tb/tb_swbus_tx_gate.sv
module tb_swbus_tx_gate;
  localparam int LIM = 5;

  logic clk = 1'b0, rst_n = 1'b0, txd_in = 1'b1, tick = 1'b0;
  logic [1:0] mode_sel = 2'b11, supply_band = 2'b10;
  logic drv_en, drv_hv, shape_en;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  swbus_tx_gate #(.TIMEOUT_TICKS(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .mode_sel(mode_sel),
    .supply_band(supply_band), .tick(tick),
    .drv_en(drv_en), .drv_hv(drv_hv), .shape_en(shape_en));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_txd(input logic v);
    @(negedge clk) txd_in = v;
    @(posedge clk); @(posedge clk); #1;
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(posedge clk); #1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic t_reset();
    txd_in = 1'b0;
    #1;
    chk("R10 drv_en in reset", drv_en, 1'b0);
    chk("R10 drv_hv in reset", drv_hv, 1'b0);
    @(negedge clk) rst_n = 1'b1; txd_in = 1'b1;
    @(posedge clk); #1;
    chk("R10 drv_en after reset", drv_en, 1'b0);
  endtask

  task automatic t_basic();
    mode_sel = 2'b11; supply_band = 2'b10;
    @(negedge clk) txd_in = 1'b0;
    @(posedge clk); #1;
    chk("R1 one edge not yet", drv_en, 1'b0);
    @(posedge clk); #1;
    chk("R1 dominant after two edges", drv_en, 1'b1);
    chk("R3 normal mode level", drv_hv, 1'b0);
    set_txd(1'b1);
    chk("R1 recessive", drv_en, 1'b0);
  endtask

  task automatic t_sleep();
    @(negedge clk) mode_sel = 2'b00;
    set_txd(1'b0);
    chk("R2 sleep no drive", drv_en, 1'b0);
    @(negedge clk) mode_sel = 2'b11; #1;
    chk("R1 drive after leaving sleep", drv_en, 1'b1);
    set_txd(1'b1);
  endtask

  task automatic t_levels();
    @(negedge clk) mode_sel = 2'b10;
    set_txd(1'b0);
    chk("R3 wake drv_en", drv_en, 1'b1);
    chk("R3 wake hv level", drv_hv, 1'b1);
    chk("R4 wake shaping", shape_en, 1'b1);
    @(negedge clk) mode_sel = 2'b01; #1;
    chk("R3 fast normal level", drv_hv, 1'b0);
    chk("R3 fast drives", drv_en, 1'b1);
    chk("R4 fast no shaping", shape_en, 1'b0);
    @(negedge clk) mode_sel = 2'b11; #1;
    chk("R4 normal shaping", shape_en, 1'b1);
    @(negedge clk) mode_sel = 2'b00; #1;
    chk("R4 sleep shaping", shape_en, 1'b1);
    @(negedge clk) mode_sel = 2'b11;
    set_txd(1'b1);
  endtask

  task automatic t_supply();
    @(negedge clk) mode_sel = 2'b10; supply_band = 2'b01;
    set_txd(1'b0);
    chk("R8 reduced drives", drv_en, 1'b1);
    chk("R8 reduced no hv", drv_hv, 1'b0);
    @(negedge clk) supply_band = 2'b00; #1;
    chk("R7 lockout drv_en", drv_en, 1'b0);
    chk("R7 lockout drv_hv", drv_hv, 1'b0);
    @(negedge clk) supply_band = 2'b11; #1;
    chk("R3 full band hv", drv_hv, 1'b1);
    @(negedge clk) mode_sel = 2'b11; supply_band = 2'b10;
    set_txd(1'b1);
  endtask

  task automatic t_timeout();
    set_txd(1'b0);
    for (int i = 1; i <= LIM; i++) begin
      pulse_tick();
      chk("R5 timeout count", drv_en, (i < LIM) ? 1'b1 : 1'b0);
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R6 held off while low", drv_en, 1'b0);
    set_txd(1'b1);
    chk("R6 recessive on rise", drv_en, 1'b0);
    @(negedge clk) txd_in = 1'b0;
    @(posedge clk); #1;
    chk("R6 no early drive", drv_en, 1'b0);
    @(posedge clk); #1;
    chk("R6 resume after two edges", drv_en, 1'b1);
    set_txd(1'b1);
  endtask

  task automatic t_clear();
    set_txd(1'b0);
    for (int i = 0; i < LIM - 1; i++) pulse_tick();
    set_txd(1'b1);
    for (int i = 0; i < 2 * LIM; i++) pulse_tick();
    set_txd(1'b0);
    for (int i = 0; i < LIM - 1; i++) pulse_tick();
    chk("R9 count restarted", drv_en, 1'b1);
    pulse_tick();
    chk("R9 full count expires", drv_en, 1'b0);
    set_txd(1'b1);
  endtask

  initial begin
    #20000;
    errors++; checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_basic();
    t_sleep();
    t_levels();
    t_supply();
    t_timeout();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule